// File: doc/BRIEF.md
# Packed Signed Multiply-Add Unit

This block is a single-stage arithmetic datapath that works on two 64-bit operand words. A one-bit operation select chooses between two functions. In the pairwise multiply-add function, each word is treated as four signed 16-bit lanes. Each lane of A is multiplied by the matching lane of B, and neighbouring products are summed into two 32-bit results. In the widening function, the low 32 bits of each word are taken as unsigned values and multiplied to a full 64-bit product.

The operands are accepted on any clock edge where `in_valid` is high. The result and `out_valid` appear on the following edge. There is no back-pressure, no saturation and no status output. The block is meant to sit inside a vector execution pipeline and be fed one operation per cycle. It is useful for dot products and filter taps, and for full-precision 32-bit unsigned multiplies.

Top module: `pmac_unit`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, `out_valid` is 0 and `result` is all zeros.
- R2: With `op_sel` = 0 (multiply-add), `result[31:0]` equals the signed product of A[15:0] and B[15:0] plus the signed product of A[31:16] and B[31:16]. Each product is kept at 32-bit precision, and the sum wraps modulo 2^32.
- R3: With `op_sel` = 0, `result[63:32]` is formed the same way from lanes A/B[47:32] and A/B[63:48], independently of the low half.
- R4: When all four 16-bit inputs that feed one 32-bit half equal 0x8000, that half of the result is 0x8000_0000: the wrapped sum, not a saturated value.
- R5: With `op_sel` = 1 (widening), `result` equals the full 64-bit unsigned product of A[31:0] and B[31:0]. For example, 0xFFFF_FFFF times 0xFFFF_FFFF gives 0xFFFF_FFFE_0000_0001.
- R6: With `op_sel` = 1, bits 63:32 of both operands have no effect on the result.
- R7: `out_valid` is high in exactly the cycle that follows a cycle in which `in_valid` was high. Back-to-back operations each give one result, in order.
- R8: When `in_valid` is low, `result` keeps its previous value, whatever the operand and select inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| in_valid | input | 1 | Operands and select are taken on this edge |
| op_sel | input | 1 | 0 = pairwise signed multiply-add, 1 = widening unsigned multiply |
| a_in | input | 64 | Operand A |
| b_in | input | 64 | Operand B |
| out_valid | output | 1 | Result is valid this cycle |
| result | output | 64 | Registered result |

## Verification
On every cycle, the assertions check the handshake timing: a result follows every accepted operation and never appears without one. They also check that the result register holds while idle. Two arithmetic cases are watched by properties as well: the all-0x8000 wrap, and a zero low operand in widening mode. Full arithmetic correctness can only be shown by the bench's scenarios. These include random operands in both modes compared against an independent lane-by-lane model, the maximum unsigned widening case, and varying the upper operand bits in widening mode to show they are ignored.

// File: rtl/pmac_pkg.sv
package pmac_pkg;

  typedef enum logic {
    OP_MADD = 1'b0,
    OP_WIDE = 1'b1
  } pmac_op_e;

endpackage

// File: rtl/pmac_rst_sync.sv
module pmac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/pmac_lane_mul.sv
module pmac_lane_mul #(
  parameter int LANE_W = 16
) (
  input  logic [LANE_W-1:0]   a_lane,
  input  logic [LANE_W-1:0]   b_lane,
  output logic [2*LANE_W-1:0] prod
);

  localparam int PROD_W = 2 * LANE_W;

  logic signed [PROD_W-1:0] a_ext;
  logic signed [PROD_W-1:0] b_ext;

  always_comb begin
    a_ext = {{LANE_W{a_lane[LANE_W-1]}}, a_lane};
    b_ext = {{LANE_W{b_lane[LANE_W-1]}}, b_lane};
    prod  = a_ext * b_ext;
  end

endmodule

// File: rtl/pmac_madd.sv
module pmac_madd #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4
) (
  input  logic [LANE_W*LANES-1:0] a_word,
  input  logic [LANE_W*LANES-1:0] b_word,
  output logic [LANE_W*LANES-1:0] sums
);

  localparam int PROD_W = 2 * LANE_W;
  localparam int PAIRS  = LANES / 2;

  logic [PROD_W-1:0] prods [LANES];

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    pmac_lane_mul #(.LANE_W(LANE_W)) u_mul (
      .a_lane (a_word[ln*LANE_W +: LANE_W]),
      .b_lane (b_word[ln*LANE_W +: LANE_W]),
      .prod   (prods[ln])
    );
  end

  for (genvar pr = 0; pr < PAIRS; pr++) begin : g_pair
    always_comb begin
      sums[pr*PROD_W +: PROD_W] = prods[2*pr] + prods[2*pr+1];
    end
  end

endmodule

// File: rtl/pmac_wide_mul.sv
module pmac_wide_mul #(
  parameter int HALF_W = 32
) (
  input  logic [HALF_W-1:0]   a_half,
  input  logic [HALF_W-1:0]   b_half,
  output logic [2*HALF_W-1:0] prod
);

  localparam int FULL_W = 2 * HALF_W;

  logic [FULL_W-1:0] a_zx;
  logic [FULL_W-1:0] b_zx;

  always_comb begin
    a_zx = {{HALF_W{1'b0}}, a_half};
    b_zx = {{HALF_W{1'b0}}, b_half};
    prod = a_zx * b_zx;
  end

endmodule

// File: rtl/pmac_unit.sv
module pmac_unit #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    op_sel,
  input  logic [LANE_W*LANES-1:0] a_in,
  input  logic [LANE_W*LANES-1:0] b_in,
  output logic                    out_valid,
  output logic [LANE_W*LANES-1:0] result
);
  import pmac_pkg::*;

  localparam int WORD_W = LANE_W * LANES;
  localparam int HALF_W = WORD_W / 2;
  localparam int PAIR_W = 2 * LANE_W;

  logic              srst_n;
  pmac_op_e          op;
  logic [WORD_W-1:0] madd_res;
  logic [WORD_W-1:0] wide_res;
  logic [WORD_W-1:0] res_d;
  logic [WORD_W-1:0] res_q;
  logic              vld_d;
  logic              vld_q;

  pmac_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pmac_madd #(.LANE_W(LANE_W), .LANES(LANES)) u_madd (
    .a_word (a_in),
    .b_word (b_in),
    .sums   (madd_res)
  );

  pmac_wide_mul #(.HALF_W(HALF_W)) u_wide (
    .a_half (a_in[HALF_W-1:0]),
    .b_half (b_in[HALF_W-1:0]),
    .prod   (wide_res)
  );

  always_comb begin
    op    = pmac_op_e'(op_sel);
    vld_d = in_valid;
    res_d = res_q;
    if (in_valid) begin
      res_d = (op == OP_WIDE) ? wide_res : madd_res;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!srst_n)
    in_valid |=> out_valid); // R7

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!srst_n)
    !in_valid |=> !out_valid); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    !in_valid |=> $stable(result)); // R8

  AST_WRAP_LOW: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && !op_sel && a_in[PAIR_W-1:0] == {2{1'b1, {(LANE_W-1){1'b0}}}}
              && b_in[PAIR_W-1:0] == {2{1'b1, {(LANE_W-1){1'b0}}}})
    |=> result[PAIR_W-1:0] == {1'b1, {(PAIR_W-1){1'b0}}}); // R4

  AST_WIDE_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && op_sel && a_in[HALF_W-1:0] == '0) |=> result == '0); // R5

endmodule

// File: tb/sim_pmac_unit.sv
module sim_pmac_unit;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        op_sel;
  logic [63:0] a_in;
  logic [63:0] b_in;
  logic        out_valid;
  logic [63:0] result;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [63:0] exp_q[$];
  string       req_q[$];

  pmac_unit u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .a_in      (a_in),
    .b_in      (b_in),
    .out_valid (out_valid),
    .result    (result)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [63:0] ref_model(input logic op, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    if (op) begin
      longint unsigned ua = longint'(a[31:0]);
      longint unsigned ub = longint'(b[31:0]);
      r = ua * ub;
    end else begin
      for (int h = 0; h < 2; h++) begin
        int s = 0;
        for (int k = 0; k < 2; k++) begin
          int p = int'($signed(a[(2*h+k)*16 +: 16])) * int'($signed(b[(2*h+k)*16 +: 16]));
          s = s + p;
        end
        r[h*32 +: 32] = s;
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic op, input logic [63:0] a, input logic [63:0] b, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    op_sel   = op;
    a_in     = a;
    b_in     = b;
    exp_q.push_back(ref_model(op, a, b));
    req_q.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_sel   = 1'($urandom);
      a_in     = {$urandom, $urandom};
      b_in     = {$urandom, $urandom};
    end
  endtask

  // monitor: pops expected items as results arrive
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R7 spurious out_valid", 64'd1, 64'd0);
      end else begin
        string rq = req_q.pop_front();
        check(rq, result, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(100000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    logic [63:0] w0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    op_sel = 1'b0;
    a_in = '0;
    b_in = '0;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {63'd0, out_valid}, 64'd0);
    check("R1 result in reset", result, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);
    check("R1 result after reset", result, 64'd0);

    // directed multiply-add
    drive(1'b0, 64'h0003_0002_FFFF_0005, 64'h0004_0007_0002_FFFD, "R2 R3 directed");
    drive(1'b0, 64'h7FFF_7FFF_8000_8000, 64'h7FFF_7FFF_8000_8000, "R4 low half wrap");
    drive(1'b0, 64'h8000_8000_0001_0001, 64'h8000_8000_0001_0001, "R4 high half wrap");
    drive(1'b0, 64'h0000_0000_1234_5678, 64'h0000_0000_0001_0000, "R3 high half independent");
    idle(2);

    // widening
    drive(1'b1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, "R5 max unsigned");
    drive(1'b1, 64'hDEAD_BEEF_0000_0000, 64'h1234_5678_9ABC_DEF0, "R5 zero operand");
    drive(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hA5A5_A5A5_FFFF_FFFF, "R6 upper bits ignored");
    idle(2);
    check("R5 literal max product", ref_model(1'b1, 64'hFFFF_FFFF, 64'hFFFF_FFFF), 64'hFFFF_FFFE_0000_0001);

    // R6: same low halves, different upper bits give the same result
    drive(1'b1, 64'h0000_0000_8765_4321, 64'h0000_0000_0FED_CBA9, "R6 reference");
    idle(2);
    w0 = result;
    drive(1'b1, 64'hFFFF_0000_8765_4321, 64'h1111_2222_0FED_CBA9, "R6 upper varied");
    idle(2);
    check("R6 results equal", result, w0);

    // R8: hold while idle
    held = result;
    idle(4);
    check("R8 result held while idle", result, held);
    check("R7 out_valid low while idle", {63'd0, out_valid}, 64'd0);

    // random back-to-back, both modes
    for (int i = 0; i < 300; i++) begin
      drive(1'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, "R2 R3 R5 random");
      if ((i % 7) == 0) idle(1);
    end
    idle(3);
    check("R7 every input produced one result", 64'(exp_q.size()), 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule